// File: doc/BRIEF.md
# Receive Character Buffer with Sticky Block Error

This block sits between a UART receive shifter and the host. Each deserialised character comes in with three error flags. The block stores it in a 256-entry first-in first-out buffer and hands it to the host over a valid/ready read port. Once the buffer is full, one more character can wait in a holding slot, so up to 257 characters are held in total. A further character that arrives while the buffer is full and the slot is occupied takes the place of the held one. In that case the overrun flag is raised when the start bit of that character is detected.

Software can look at errors in two ways. In character mode, the status error bits show the flags of the character at the head of the buffer, so status is read before each data byte. In block mode, the status error bits come from a sticky latch. That latch collects the flags of errored characters, so one status read covers a whole burst. A command selects when the latch is updated: when an errored character is unloaded by the host (the default), or when it is loaded into the buffer. The load setting reports a problem up to a full buffer depth sooner. The latch is cleared only by a receiver-reset command or by chip reset.

The input side has no ready signal. The shifter cannot stall, so excess characters go to the holding slot or replace the one already there. The output side follows valid/ready rules. `out_valid` is high whenever the buffer holds a character. The head character is removed on a clock edge where both `out_valid` and `out_ready` are high. The data and flags stay stable while `out_ready` is low. Status outputs are continuous and never change the buffer contents.

Top module: `rx_block_fifo`

## Requirements
- R1: After chip reset, fill is 0, out_valid is 0, hold_valid is 0, st_overrun is 0, st_err is 0, and the latch update mode is unload.
- R2: Characters leave in arrival order with their own flags (in_err bit 0 parity, bit 1 framing, bit 2 break). out_valid is high exactly when fill is non-zero, fill counts the stored characters, and a character is removed on an edge where out_valid and out_ready are both high.
- R3: When in_valid is high on an edge where fill is 256 (or the holding slot is already occupied), the character goes to the holding slot and hold_valid rises. There is no input back-pressure.
- R4: When the holding slot is occupied and fill is below 256, the held character enters the buffer on the next edge. A read therefore frees a slot, and the held character arrives one cycle after that read.
- R5: A character arriving while the buffer is full and the slot is occupied replaces the held character, and the buffer contents stay the same.
- R6: st_overrun goes high on the edge after start_det is sampled while the buffer is full and the slot is occupied. Once set, it stays high until a receiver reset or chip reset.
- R7: With block_mode low, st_err equals the flags of the head character, or 0 when the buffer is empty.
- R8: With block_mode high, st_err shows the sticky latch. In unload mode (the default, and after command code 3), each latch bit is set when a character with that flag is removed by the host.
- R9: After command code 2 (load mode), each latch bit is set when a character with that flag enters the buffer, either directly or from the holding slot.
- R10: Command code 1 (receiver reset) empties the buffer and the holding slot and clears st_overrun and the latch in one cycle, and keeps the latch update mode. Command code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| in_valid | input | 1 | A received character is presented this cycle |
| in_data | input | 8 | Received character |
| in_err | input | 3 | Flags of that character: parity, framing, break |
| start_det | input | 1 | Start bit of a new character detected |
| out_valid | output | 1 | Head character available |
| out_ready | input | 1 | Host takes the head character |
| out_data | output | 8 | Head character |
| out_err | output | 3 | Flags of the head character |
| block_mode | input | 1 | Select sticky latch (1) or per-character (0) status |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 none, 1 receiver reset, 2 latch on load, 3 latch on unload |
| st_err | output | 3 | Status error bits |
| st_overrun | output | 1 | Sticky overrun flag |
| fill | output | 9 | Number of characters in the buffer, 0 to 256 |
| hold_valid | output | 1 | Holding slot occupied |

## Verification
Every result is registered once. A write, read, command or start-bit strobe sampled on one edge shows up on fill, out_valid, hold_valid, st_overrun and the latch right after that edge. The exception is a held character, which enters the buffer one edge later than the read that made room for it. st_err and the head data are combinational views of that state, so they are correct in the same cycle.

The bench drives inputs shortly after the rising edge and updates a behavioural queue model on each rising edge. It compares every output at the falling edge, so each comparison sees exactly one edge's worth of change.

// File: rtl/rbf_pkg.sv
`timescale 1ns/1ps
package rbf_pkg;
  typedef enum logic [1:0] {
    CMD_NONE        = 2'd0,
    CMD_RX_RESET    = 2'd1,
    CMD_LATCH_LOAD  = 2'd2,
    CMD_LATCH_UNLD  = 2'd3
  } rbf_cmd_e;

  localparam int ERR_PARITY  = 0;
  localparam int ERR_FRAMING = 1;
  localparam int ERR_BREAK   = 2;
endpackage

// File: rtl/rbf_store.sv
`timescale 1ns/1ps
module rbf_store #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_ptr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_ptr] <= wr_word;
  end

  assign rd_word = cells[rd_ptr];
endmodule

// File: rtl/rbf_ctrl.sv
`timescale 1ns/1ps
module rbf_ctrl #(
  parameter int WORD_W = 11,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              pop,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic [AW-1:0]     wr_ptr,
  output logic [AW-1:0]     rd_ptr,
  output logic [CW-1:0]     count,
  output logic              hold_valid,
  output logic              fifo_full
);
  logic [WORD_W-1:0] hold_word_q;
  logic              hold_q;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     count_q;
  logic              move_hold, direct_wr, load_hold;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifo_full = (count_q == CW'(DEPTH));
  assign move_hold = hold_q && !fifo_full;
  assign direct_wr = !hold_q && in_valid && !fifo_full;
  assign load_hold = in_valid && (hold_q || fifo_full);
  assign push      = move_hold || direct_wr;
  assign push_word = hold_q ? hold_word_q : in_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q      <= '0;
      rptr_q      <= '0;
      count_q     <= '0;
      hold_q      <= 1'b0;
      hold_word_q <= '0;
    end else if (clr) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      if (push) wptr_q <= ptr_next(wptr_q);
      if (pop)  rptr_q <= ptr_next(rptr_q);
      count_q <= count_q + CW'(push) - CW'(pop);
      if (load_hold) begin
        hold_q      <= 1'b1;
        hold_word_q <= in_word;
      end else if (move_hold) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign wr_ptr     = wptr_q;
  assign rd_ptr     = rptr_q;
  assign count      = count_q;
  assign hold_valid = hold_q;
endmodule

// File: rtl/rbf_status.sv
`timescale 1ns/1ps
module rbf_status #(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sel_load,
  input  logic             sel_unload,
  input  logic             block_mode,
  input  logic             push,
  input  logic [ERR_W-1:0] push_err,
  input  logic             pop,
  input  logic             head_valid,
  input  logic [ERR_W-1:0] head_err,
  input  logic             start_det,
  input  logic             hold_valid,
  input  logic             fifo_full,
  output logic [ERR_W-1:0] st_err,
  output logic             st_overrun
);
  logic             on_load_q;
  logic             ovr_q;
  logic [ERR_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          on_load_q <= 1'b0;
    else if (sel_load)   on_load_q <= 1'b1;
    else if (sel_unload) on_load_q <= 1'b0;
  end

  for (genvar b = 0; b < ERR_W; b++) begin : g_latch
    logic hit;
    assign hit = on_load_q ? (push && push_err[b]) : (pop && head_err[b]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q[b] <= 1'b0;
      else if (clr) latch_q[b] <= 1'b0;
      else if (hit) latch_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ovr_q <= 1'b0;
    else if (clr) ovr_q <= 1'b0;
    else if (start_det && hold_valid && fifo_full) ovr_q <= 1'b1;
  end

  assign st_err     = block_mode ? latch_q : (head_valid ? head_err : '0);
  assign st_overrun = ovr_q;
endmodule

// File: rtl/rx_block_fifo.sv
`timescale 1ns/1ps
module rx_block_fifo #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1,
  localparam int WORD_W = DATA_W + ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ERR_W-1:0]  in_err,
  input  logic              start_det,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ERR_W-1:0]  out_err,
  input  logic              block_mode,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic [ERR_W-1:0]  st_err,
  output logic              st_overrun,
  output logic [CW-1:0]     fill,
  output logic              hold_valid
);
  import rbf_pkg::*;

  rbf_cmd_e          cmd_e;
  logic              clr, sel_load, sel_unload;
  logic              push, pop, fifo_full;
  logic [WORD_W-1:0] push_word, head_word;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  assign cmd_e      = rbf_cmd_e'(cmd_code);
  assign clr        = cmd_valid && (cmd_e == CMD_RX_RESET);
  assign sel_load   = cmd_valid && (cmd_e == CMD_LATCH_LOAD);
  assign sel_unload = cmd_valid && (cmd_e == CMD_LATCH_UNLD);

  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;

  rbf_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_word   ({in_err, in_data}),
    .pop       (pop),
    .push      (push),
    .push_word (push_word),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .hold_valid(hold_valid),
    .fifo_full (fifo_full)
  );

  rbf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (push),
    .wr_ptr (wr_ptr),
    .wr_word(push_word),
    .rd_ptr (rd_ptr),
    .rd_word(head_word)
  );

  rbf_status #(.ERR_W(ERR_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .sel_load  (sel_load),
    .sel_unload(sel_unload),
    .block_mode(block_mode),
    .push      (push),
    .push_err  (push_word[WORD_W-1:DATA_W]),
    .pop       (pop),
    .head_valid(out_valid),
    .head_err  (head_word[WORD_W-1:DATA_W]),
    .start_det (start_det),
    .hold_valid(hold_valid),
    .fifo_full (fifo_full),
    .st_err    (st_err),
    .st_overrun(st_overrun)
  );

  assign out_data = head_word[DATA_W-1:0];
  assign out_err  = head_word[WORD_W-1:DATA_W];
  assign fill     = count;
endmodule

// File: rtl/rbf_checker.sv
`timescale 1ns/1ps
module rbf_checker #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          start_det,
  input logic          out_valid,
  input logic          out_ready,
  input logic          cmd_valid,
  input logic [1:0]    cmd_code,
  input logic          st_overrun,
  input logic [CW-1:0] fill,
  input logic          hold_valid
);
  logic rxr, full, pop;
  assign rxr  = cmd_valid && (cmd_code == 2'd1);
  assign full = (fill == CW'(DEPTH));
  assign pop  = out_valid && out_ready;

  // R2: level never exceeds the depth
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  // R3: a character offered to a full buffer lands in the holding slot
  a_r3_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hold_valid && in_valid && !rxr) |=> hold_valid);

  // R4: held character drains into freed space on the next edge
  a_r4_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !full && !rxr) |=>
      (int'(fill) == int'($past(fill)) + 1 - int'($past(pop))));

  // R5: overrunning character leaves the buffer full and the slot in use
  a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && hold_valid && in_valid && !pop && !rxr) |=> (full && hold_valid));

  // R6: overrun raised by a start bit while the slot is stuck
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && hold_valid && full && !rxr) |=> st_overrun);

  // R6: overrun is sticky
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_overrun && !rxr) |=> st_overrun);

  // R10: receiver reset empties everything in one cycle
  a_r10_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rxr |=> (fill == '0 && !hold_valid && !st_overrun));
endmodule

bind rx_block_fifo rbf_checker #(.DEPTH(DEPTH)) u_rbf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .start_det (start_det),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .st_overrun(st_overrun),
  .fill      (fill),
  .hold_valid(hold_valid)
);

// File: tb/rx_block_fifo_bench.sv
`timescale 1ns/1ps
module rx_block_fifo_bench;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] in_err = '0;
  logic       start_det = 1'b0;
  logic       out_ready = 1'b0;
  logic       block_mode = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_code = '0;
  logic       out_valid;
  logic [7:0] out_data;
  logic [2:0] out_err;
  logic [2:0] st_err;
  logic       st_overrun;
  logic [8:0] fill;
  logic       hold_valid;

  int vectors = 0;
  int miscompares = 0;
  string ph = "R1";

  always #10 clk = ~clk;

  rx_block_fifo u_rx_block_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_err(in_err), .start_det(start_det), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_err(out_err),
    .block_mode(block_mode), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .st_err(st_err), .st_overrun(st_overrun), .fill(fill),
    .hold_valid(hold_valid)
  );

  // behavioural reference
  logic [10:0] mq[$];
  bit          mh = 0;
  logic [10:0] mhw = '0;
  bit          movr = 0;
  logic [2:0]  mlat = '0;
  bit          mload = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); mh = 0; movr = 0; mlat = '0; mload = 0;
    end else begin
      automatic bit full = (mq.size() == DEPTH);
      automatic bit pop  = (mq.size() > 0) && out_ready;
      automatic bit rxr  = cmd_valid && (cmd_code == 2'd1);
      if (rxr) begin
        mq.delete(); mh = 0; movr = 0; mlat = '0;
      end else begin
        if (start_det && mh && full) movr = 1;
        if (pop) begin
          automatic logic [10:0] h = mq.pop_front();
          if (!mload) mlat |= h[10:8];
        end
        if (mh && !full) begin
          mq.push_back(mhw);
          if (mload) mlat |= mhw[10:8];
        end else if (!mh && in_valid && !full) begin
          mq.push_back({in_err, in_data});
          if (mload) mlat |= in_err;
        end
        if (in_valid && (mh || full)) begin
          mh = 1; mhw = {in_err, in_data};
        end else if (mh && !full) begin
          mh = 0;
        end
        if (cmd_valid && cmd_code == 2'd2) mload = 1;
        if (cmd_valid && cmd_code == 2'd3) mload = 0;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d", tag, ph, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    automatic int sz = mq.size();
    automatic logic [2:0] exp_st = block_mode ? mlat : (sz > 0 ? mq[0][10:8] : 3'd0);
    chk(rst_n ? "R2" : "R1", "fill", int'(fill), sz);
    chk(rst_n ? "R2" : "R1", "out_valid", int'(out_valid), int'(sz > 0));
    chk(rst_n ? "R3" : "R1", "hold_valid", int'(hold_valid), int'(mh));
    chk(rst_n ? "R6" : "R1", "st_overrun", int'(st_overrun), int'(movr));
    chk(rst_n ? (block_mode ? "R8" : "R7") : "R1", "st_err", int'(st_err), int'(exp_st));
    if (sz > 0) begin
      chk("R2", "out_data", int'(out_data), int'(mq[0][7:0]));
      chk("R2", "out_err", int'(out_err), int'(mq[0][10:8]));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic idle();
    in_valid = 0; start_det = 0; out_ready = 0; cmd_valid = 0; cmd_code = 0;
  endtask

  task automatic put(logic [7:0] d, logic [2:0] e);
    in_valid = 1; in_data = d; in_err = e; cyc(); in_valid = 0;
  endtask

  task automatic cmd(logic [1:0] c);
    cmd_valid = 1; cmd_code = c; cyc(); cmd_valid = 0; cmd_code = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1; cyc();

    ph = "R7";
    put(8'h11, 3'b000); put(8'h22, 3'b001); put(8'h33, 3'b010);
    put(8'h44, 3'b100); put(8'h55, 3'b000);
    cyc(2);
    out_ready = 1; cyc(6); out_ready = 0;

    ph = "R8";
    block_mode = 1;
    put(8'hA0, 3'b010); put(8'hA1, 3'b000);
    cyc(2);
    out_ready = 1; cyc(3); out_ready = 0;
    ph = "R10"; cmd(2'd1); cyc(2);

    ph = "R9";
    cmd(2'd2);
    put(8'hB0, 3'b100); put(8'hB1, 3'b001);
    cyc(2);
    cmd(2'd0);
    ph = "R10"; cmd(2'd1); cyc();
    block_mode = 0;

    ph = "R3";
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1; in_data = 8'(i); in_err = (i == 10) ? 3'b001 : 3'b000; cyc();
    end
    put(8'hC7, 3'b000);
    cyc();
    ph = "R6"; start_det = 1; cyc(); start_det = 0;
    ph = "R5"; put(8'hC8, 3'b100); cyc();
    ph = "R4"; out_ready = 1; cyc(); out_ready = 0; cyc(2);
    ph = "R8"; block_mode = 1; cmd(2'd3);
    out_ready = 1; cyc(DEPTH + 4); out_ready = 0;
    ph = "R10"; cmd(2'd1); cyc(2);

    ph = "R10"; cmd(2'd2);
    rst_n = 0; cyc(2); rst_n = 1; cyc();
    put(8'hD0, 3'b111); cyc(2);
    out_ready = 1; cyc(2); out_ready = 0;
    block_mode = 0;

    ph = "R2";
    for (int i = 0; i < 6000; i++) begin
      automatic int rdp = (i % 2000 < 900) ? 3 : 60;
      in_valid  = ($urandom % 100) < 45;
      in_data   = 8'($urandom);
      in_err    = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      start_det = ($urandom % 100) < 15;
      out_ready = ($urandom % 100) < rdp;
      cmd_valid = ($urandom % 100) < 2;
      cmd_code  = 2'($urandom);
      if ($urandom % 200 == 0) block_mode = ~block_mode;
      cyc();
    end
    idle(); cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule